// File: doc/BRIEF.md
# Input Change Interrupt Peripheral

This block watches a small group of asynchronous push-button and switch inputs and tells a processor when any of them moves. It brings every raw input into the clock domain through a two-flop chain, compares the synchronized value against a copy taken one cycle earlier, and raises a single active-high, level-sensitive interrupt request whenever the two differ.

Software handles the request by reading the one state register over a memory-mapped slave read port. That read returns the synchronized inputs packed into a 32-bit word, and the same read strobe withdraws the request. There is no separate status, mask or acknowledge register. A change that arrives in the same cycle as the servicing read keeps the request raised, so no edge is lost. The block has no debouncing. A bouncing contact therefore produces one request for each settled change that it sees.

Top module: `icirq_top`

## Requirements
- R1: While reset is held and right after it is released, `irq` is 0 and `rd_data` is 0.
- R2: A raw input change enters the internal state only after two register stages. A read whose strobe is sampled on the same clock edge that first captures the change still returns the old value.
- R3: When an input changes and then holds, `irq` rises on the third rising clock edge after the change, counting the edge that first captures it, and not earlier.
- R4: Once `irq` is high, it stays high on every cycle in which `rd_en` is low.
- R5: An `rd_en` sampled high with no change detected in that cycle drives `irq` to 0 on that edge.
- R6: If a change is detected in the same cycle that `rd_en` is sampled high, `irq` is 1 after that edge.
- R7: A read returns `{24'b0, switches[3:0], keys[3:0]}` of the synchronized inputs on `rd_data` one cycle after the strobe, which is a fixed read latency of 1. There is a single register address, so the port has no address input.
- R8: A single input change followed by a servicing read gives exactly one assertion of `irq`. Once that read has cleared it, `irq` stays 0 until the inputs change again.
- R9: `rd_data` keeps its value in every cycle in which `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous and release is synchronized inside the block |
| keys_async | input | 4 | Raw push-button inputs |
| switches_async | input | 4 | Raw switch inputs |
| rd_en | input | 1 | Read strobe for the state register, which also services the request |
| rd_data | output | 32 | Registered read data, valid one cycle after `rd_en` |
| irq | output | 1 | Active-high level interrupt request |

## Verification
A bad synchronizer or previous-value register shows up at the ports as a request that rises a cycle early or late, a request that never rises at all, or a request that re-fires after a read, all within three or four cycles of an input change. A bad set or clear term shows as a request that drops without a read, survives a read, or is lost when a change meets a read. A packing or enable fault in the read path appears on the first read as a wrong field position or a stale word. The bench compares `irq` on every cycle and compares `rd_data` on every cycle, including the held cycles between reads, so each of these faults surfaces within one cycle of the first stimulus that exposes it.

// File: rtl/icirq_pkg.sv
package icirq_pkg;
  localparam int unsigned ICIRQ_KEY_W   = 4;
  localparam int unsigned ICIRQ_SW_W    = 4;
  localparam int unsigned ICIRQ_DATA_W  = 32;
  localparam int unsigned ICIRQ_STAGES  = 2;
  localparam int unsigned ICIRQ_RST_STG = 2;

  // Action taken on the request flop in a given cycle
  typedef enum logic [1:0] {
    REQ_HOLD  = 2'd0,
    REQ_SET   = 2'd1,
    REQ_CLEAR = 2'd2
  } req_act_e;
endpackage

// File: rtl/icirq_rst_sync.sv
module icirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/icirq_sync.sv
module icirq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  // Stage 0 samples the raw bus and each later stage samples the one before it
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = raw_in;
      end else begin : g_next
        always_comb stage_d[g] = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/icirq_change_irq.sv
module icirq_change_irq
  import icirq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_in,
  input  logic         rd_en,
  output logic         change,
  output logic         irq
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;
  logic         irq_q;
  logic         irq_d;
  req_act_e     act;

  // The previous copy follows the synchronized value every cycle
  always_comb begin
    prev_d = cur_in;
    change = |(cur_in ^ prev_q);
  end

  // A detected change wins over a read so that the change is not dropped
  always_comb begin
    if (change)     act = REQ_SET;
    else if (rd_en) act = REQ_CLEAR;
    else            act = REQ_HOLD;
  end

  always_comb begin
    unique case (act)
      REQ_SET:   irq_d = 1'b1;
      REQ_CLEAR: irq_d = 1'b0;
      default:   irq_d = irq_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;

  p_set_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    change |=> irq);
  p_hold_until_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_en) |=> irq);
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !change) |=> !irq);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !change) |=> !irq);
endmodule

// File: rtl/icirq_rd_port.sv
module icirq_rd_port #(
  parameter int unsigned KEY_W  = 4,
  parameter int unsigned SW_W   = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [KEY_W-1:0]  keys_s,
  input  logic [SW_W-1:0]   sw_s,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned USED_W = KEY_W + SW_W;
  localparam int unsigned PAD_W  = DATA_W - USED_W;

  logic [DATA_W-1:0] word_c;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;

  // Keys sit in the low bits and switches directly above them
  generate
    if (PAD_W > 0) begin : g_pad
      always_comb word_c = {{PAD_W{1'b0}}, sw_s, keys_s};
    end else begin : g_nopad
      always_comb word_c = {sw_s, keys_s};
    end
  endgenerate

  always_comb begin
    data_d = rd_en ? word_c : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign rd_data = data_q;

  p_hold_between_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data[USED_W-1:0] == $past({sw_s, keys_s})));
endmodule

// File: rtl/icirq_top.sv
module icirq_top
  import icirq_pkg::*;
#(
  parameter int unsigned KEY_W   = ICIRQ_KEY_W,
  parameter int unsigned SW_W    = ICIRQ_SW_W,
  parameter int unsigned DATA_W  = ICIRQ_DATA_W,
  parameter int unsigned STAGES  = ICIRQ_STAGES,
  parameter int unsigned RST_STG = ICIRQ_RST_STG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  keys_async,
  input  logic [SW_W-1:0]   switches_async,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int unsigned IN_W = KEY_W + SW_W;

  logic            rst_int_n;
  logic [IN_W-1:0] raw_bus;
  logic [IN_W-1:0] sync_bus;
  logic            change;

  assign raw_bus = {switches_async, keys_async};

  icirq_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  icirq_sync #(.W(IN_W), .STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .raw_in   (raw_bus),
    .sync_out (sync_bus)
  );

  icirq_change_irq #(.W(IN_W)) u_chg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cur_in (sync_bus),
    .rd_en  (rd_en),
    .change (change),
    .irq    (irq)
  );

  icirq_rd_port #(.KEY_W(KEY_W), .SW_W(SW_W), .DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rd_en   (rd_en),
    .keys_s  (sync_bus[KEY_W-1:0]),
    .sw_s    (sync_bus[IN_W-1:KEY_W]),
    .rd_data (rd_data)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!irq && rd_data == '0));
  p_change_wins_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (change && rd_en) |=> irq);
endmodule

// File: tb/tb_icirq_top.sv
`timescale 1ns/1ps
module tb_icirq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  keys;
  logic [3:0]  sws;
  logic        rd_en;
  logic [31:0] rd_data;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  icirq_top dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .keys_async     (keys),
    .switches_async (sws),
    .rd_en          (rd_en),
    .rd_data        (rd_data),
    .irq            (irq)
  );

  // Reference model built from the requirements
  logic [7:0]  m_s1, m_s2, m_prev;
  logic        m_irq;
  logic [31:0] m_rd;

  function automatic logic f_irq_next(logic [7:0] cur, logic [7:0] prv,
                                      logic rd, logic now);
    if (cur != prv) return 1'b1;
    if (rd)         return 1'b0;
    return now;
  endfunction

  function automatic logic [31:0] f_word(logic [7:0] s);
    return {24'h0, s[7:4], s[3:0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_irq <= 1'b0; m_rd <= '0;
    end else begin
      m_s1   <= {sws, keys};
      m_s2   <= m_s1;
      m_prev <= m_s2;
      m_irq  <= f_irq_next(m_s2, m_prev, rd_en, m_irq);
      if (rd_en) m_rd <= f_word(m_s2);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1C1A_0007));
    rst_n = 1'b0; keys = '0; sws = '0; rd_en = 1'b0;
    repeat (3) cyc();
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    chk("R1 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk("R1 irq after release", {31'h0, irq}, 32'h0);
    chk("R1 rd_data after release", rd_data, 32'h0);

    // Change arrives together with a read: the read still sees the old state
    keys = 4'h5; sws = 4'hA; rd_en = 1'b1;
    cyc();
    chk("R2 read on capture edge", rd_data, 32'h0);
    rd_en = 1'b0;
    cyc();
    chk("R3 not yet after two edges", {31'h0, irq}, 32'h0);
    cyc();
    chk("R3 raised on third edge", {31'h0, irq}, 32'h1);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R4 held without read", {31'h0, irq}, 32'h1);
      chk("R9 data held", rd_data, 32'h0);
    end
    rd_en = 1'b1;
    cyc();
    chk("R5 read clears", {31'h0, irq}, 32'h0);
    chk("R7 packed word", rd_data, 32'h0000_00A5);
    rd_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk("R8 single assertion", {31'h0, irq}, 32'h0);
    end

    // Back-to-back changes with the read meeting the second detection
    keys = 4'h1;
    cyc();
    keys = 4'h2;
    cyc();
    cyc();
    chk("R3 first change raised", {31'h0, irq}, 32'h1);
    rd_en = 1'b1;
    cyc();
    chk("R6 change beats read", {31'h0, irq}, 32'h1);
    chk("R7 word at coincident read", rd_data, 32'h0000_00A2);
    rd_en = 1'b0;
    cyc();
    chk("R4 still held", {31'h0, irq}, 32'h1);
    rd_en = 1'b1;
    cyc();
    chk("R5 later read clears", {31'h0, irq}, 32'h0);
    rd_en = 1'b0;
    cyc();

    // Random traffic against the reference model
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 8) == 0) begin
        keys = 4'($urandom);
        sws  = 4'($urandom);
      end
      rd_en = (($urandom % 4) == 0);
      cyc();
      chk("R3 R4 R5 R6 R8 random irq", {31'h0, irq}, {31'h0, m_irq});
      chk("R7 R9 random rd_data", rd_data, m_rd);
    end
    finish_run();
  end
endmodule